// File: doc/BRIEF.md
# USB Endpoint Mode Control Registers

This block holds the per-endpoint mode and status state for two non-control USB endpoints. Each endpoint owns an 8-bit register that packs a stall flag, an interrupt enable for NAK outcomes, a sticky flag for ACK-completed transactions and a 4-bit mode field. Firmware reads and writes the registers over a simple byte-wide bus. The serial interface engine (SIE) reports the outcome of each finished transaction, and on every ACK outcome it writes the register of that endpoint.

For each IN or OUT token the block returns, combinationally, whether the endpoint answers with ACK, NAK, STALL or stays silent. It raises a one-cycle interrupt per endpoint when a transaction completes with ACK, and also when it completes with NAK if that endpoint has NAK interrupts enabled. After an acknowledged transfer in an "ACK" mode, the SIE moves the endpoint to the matching "NAK" mode, which hands the endpoint back to firmware.

Both registers share one update strobe. An SIE update wins over firmware, and it drops a firmware write in the same cycle to either register, not only to the register the SIE writes. Firmware is expected to read back after writing.

Top module: `usb_ep_mode_ctrl`

## Requirements
- R1: After reset both registers read 0x00. Register layout: bit 7 stall, bit 6 reserved (always reads 0, writes ignored), bit 5 NAK interrupt enable, bit 4 ACK-completed flag, bits 3:0 mode.
- R2: Firmware address 0x45 selects the endpoint-1 register (index 0) and 0x46 the endpoint-2 register (index 1); `fw_rdata` shows the selected register combinationally, and any other address reads 0x00.
- R3: Mode encoding: 0 disabled, 1 NAK-IN, 2 ACK-IN, 3 NAK-OUT, 4 ACK-OUT, 5 NAK-IN/OUT, 6..15 disabled. Handshake codes on `tok_hs`: 0 none, 1 ACK, 2 NAK, 3 STALL. An IN token gets NAK in modes 1 and 5 and ACK in mode 2; an OUT token gets NAK in modes 3 and 5 and ACK in mode 4; every other case gets none, as does any cycle without `tok_valid`.
- R4: With the stall bit set, an IN token in mode 2 and an OUT token in mode 4 get STALL; the stall bit changes no other answer.
- R5: A completed transaction reported with `done_ack`=1 sets bit 4 of that endpoint's register at the next clock edge.
- R6: A firmware write that takes effect clears bit 4, whatever value bit 4 of the written data holds.
- R7: `ep_irq[i]` is high for one cycle, the cycle after a completion report for endpoint i, when the outcome is ACK, or when it is NAK and bit 5 of that register is 1; a NAK with bit 5 clear raises no interrupt.
- R8: An ACKed IN completion in mode 2 changes the mode to 1; an ACKed OUT completion in mode 4 changes it to 3; ACKed completions in other modes leave the mode unchanged.
- R9: When an SIE update and a firmware write hit the same register in the same cycle, the SIE update is applied and the firmware write is lost.
- R10: An SIE update to either register drops a firmware write to the other register in the same cycle; a NAK completion is not an update and does not block firmware writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_addr | input | 8 | Firmware register address |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Firmware read data for `fw_addr` |
| tok_valid | input | 1 | A token is being answered this cycle |
| tok_ep | input | 1 | Token endpoint index (0 = endpoint 1, 1 = endpoint 2) |
| tok_in | input | 1 | Token direction, 1 = IN, 0 = OUT |
| tok_hs | output | 2 | Handshake to send: 0 none, 1 ACK, 2 NAK, 3 STALL |
| done_valid | input | 1 | SIE reports a finished transaction |
| done_ep | input | 1 | Endpoint index of the finished transaction |
| done_in | input | 1 | Direction of the finished transaction, 1 = IN |
| done_ack | input | 1 | 1 = ended with ACK, 0 = ended with NAK |
| ep_irq | output | 2 | One-cycle endpoint interrupt pulses, bit i for index i |

## Verification
The hardest situation to reach is the shared-strobe collision: an ACK completion on one endpoint landing in exactly the clock cycle of a firmware write to the other endpoint, where the firmware data must vanish. The bench drives both the completion report and the firmware write on the same falling edge so that one rising edge samples both, then reads both registers back. It also repeats the pairing with a NAK completion to show that only ACK updates block firmware, and pairs an update with a write to the same register to show the SIE value wins.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  localparam int REG_W = 8;

  // bit positions inside one endpoint register
  localparam int BIT_STALL = 7;
  localparam int BIT_RSV   = 6;
  localparam int BIT_NAKIE = 5;
  localparam int BIT_ACKED = 4;
  localparam int MODE_W    = 4;

  // mode field encodings
  localparam logic [MODE_W-1:0] MODE_OFF     = 4'd0;
  localparam logic [MODE_W-1:0] MODE_NAK_IN  = 4'd1;
  localparam logic [MODE_W-1:0] MODE_ACK_IN  = 4'd2;
  localparam logic [MODE_W-1:0] MODE_NAK_OUT = 4'd3;
  localparam logic [MODE_W-1:0] MODE_ACK_OUT = 4'd4;
  localparam logic [MODE_W-1:0] MODE_NAK_IO  = 4'd5;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

endpackage

// File: rtl/usb_ep_hs_decode.sv
module usb_ep_hs_decode
  import usb_ep_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              stall,
  input  logic              is_in,
  output hs_e               hs
);

  always_comb begin
    hs = HS_NONE;
    unique case (mode)
      MODE_NAK_IN:  if (is_in)  hs = HS_NAK;
      MODE_ACK_IN:  if (is_in)  hs = stall ? HS_STALL : HS_ACK;
      MODE_NAK_OUT: if (!is_in) hs = HS_NAK;
      MODE_ACK_OUT: if (!is_in) hs = stall ? HS_STALL : HS_ACK;
      MODE_NAK_IO:  hs = HS_NAK;
      default:      hs = HS_NONE;
    endcase
  end

endmodule

// File: rtl/usb_ep_update_arb.sv
module usb_ep_update_arb #(
  parameter int NUM_EP = 2
) (
  input  logic [NUM_EP-1:0] fw_hit,
  input  logic              fw_wr_en,
  input  logic [NUM_EP-1:0] sie_hit,
  input  logic              sie_upd,
  output logic [NUM_EP-1:0] fw_we,
  output logic [NUM_EP-1:0] sie_we
);

  // one shared update strobe: any SIE update masks every firmware write
  always_comb begin
    for (int i = 0; i < NUM_EP; i++) begin
      sie_we[i] = sie_upd && sie_hit[i];
      fw_we[i]  = fw_wr_en && fw_hit[i] && !sie_upd;
    end
  end

endmodule

// File: rtl/usb_ep_mode_reg.sv
module usb_ep_mode_reg
  import usb_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_we,
  input  logic [REG_W-1:0] fw_data,
  input  logic             sie_we,
  input  logic             sie_in,
  input  logic             done_hit,
  input  logic             done_ack,
  output logic [REG_W-1:0] reg_q,
  output logic             irq_q
);

  logic [REG_W-1:0]  reg_d;
  logic              reg_en;
  logic              irq_d;
  logic [MODE_W-1:0] mode_q;
  logic              unused_fw_bits;

  assign mode_q         = reg_q[MODE_W-1:0];
  assign unused_fw_bits = ^{fw_data[BIT_RSV], fw_data[BIT_ACKED]};
  assign reg_en         = fw_we || sie_we;
  assign irq_d          = done_hit && (done_ack || reg_q[BIT_NAKIE]);

  always_comb begin
    reg_d = reg_q;
    if (sie_we) begin
      reg_d[BIT_ACKED] = 1'b1;
      if (sie_in && (mode_q == MODE_ACK_IN))
        reg_d[MODE_W-1:0] = MODE_NAK_IN;
      else if (!sie_in && (mode_q == MODE_ACK_OUT))
        reg_d[MODE_W-1:0] = MODE_NAK_OUT;
    end else if (fw_we) begin
      reg_d[BIT_STALL]    = fw_data[BIT_STALL];
      reg_d[BIT_RSV]      = 1'b0;
      reg_d[BIT_NAKIE]    = fw_data[BIT_NAKIE];
      reg_d[BIT_ACKED]    = 1'b0;
      reg_d[MODE_W-1:0]   = fw_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else if (reg_en) begin
      reg_q <= reg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/usb_ep_mode_ctrl.sv
module usb_ep_mode_ctrl
  import usb_ep_pkg::*;
#(
  parameter int                 NUM_EP    = 2,
  parameter int                 ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h45,
  localparam int                EP_W      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_wr_en,
  input  logic [ADDR_W-1:0] fw_addr,
  input  logic [REG_W-1:0]  fw_wdata,
  output logic [REG_W-1:0]  fw_rdata,
  input  logic              tok_valid,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_in,
  output logic [1:0]        tok_hs,
  input  logic              done_valid,
  input  logic [EP_W-1:0]   done_ep,
  input  logic              done_in,
  input  logic              done_ack,
  output logic [NUM_EP-1:0] ep_irq
);

  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [NUM_EP-1:0]            fw_hit;
  logic [NUM_EP-1:0]            done_hit;
  logic [NUM_EP-1:0]            fw_we;
  logic [NUM_EP-1:0]            sie_we;
  logic                         sie_upd;
  logic [NUM_EP-1:0][REG_W-1:0] ep_reg;
  hs_e  [NUM_EP-1:0]            ep_hs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign sie_upd = done_valid && done_ack && (int'(done_ep) < NUM_EP);

  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      assign fw_hit[g]   = (fw_addr == BASE_ADDR + ADDR_W'(g));
      assign done_hit[g] = done_valid && (done_ep == EP_W'(g));

      usb_ep_mode_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .fw_we    (fw_we[g]),
        .fw_data  (fw_wdata),
        .sie_we   (sie_we[g]),
        .sie_in   (done_in),
        .done_hit (done_hit[g]),
        .done_ack (done_ack),
        .reg_q    (ep_reg[g]),
        .irq_q    (ep_irq[g])
      );

      usb_ep_hs_decode u_dec (
        .mode  (ep_reg[g][MODE_W-1:0]),
        .stall (ep_reg[g][BIT_STALL]),
        .is_in (tok_in),
        .hs    (ep_hs[g])
      );
    end
  endgenerate

  usb_ep_update_arb #(.NUM_EP(NUM_EP)) u_arb (
    .fw_hit   (fw_hit),
    .fw_wr_en (fw_wr_en),
    .sie_hit  (done_hit),
    .sie_upd  (sie_upd),
    .fw_we    (fw_we),
    .sie_we   (sie_we)
  );

  always_comb begin
    fw_rdata = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (fw_hit[i]) fw_rdata = ep_reg[i];
    end
  end

  always_comb begin
    tok_hs = HS_NONE;
    if (tok_valid && (int'(tok_ep) < NUM_EP)) tok_hs = ep_hs[tok_ep];
  end

endmodule

// File: rtl/usb_ep_mode_ctrl_chk.sv
module usb_ep_mode_ctrl_chk
  import usb_ep_pkg::*;
#(
  parameter int                NUM_EP    = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h45,
  parameter int                EP_W      = 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         fw_wr_en,
  input logic [ADDR_W-1:0]            fw_addr,
  input logic                         tok_valid,
  input logic [EP_W-1:0]              tok_ep,
  input logic [1:0]                   tok_hs,
  input logic                         done_valid,
  input logic [EP_W-1:0]              done_ep,
  input logic                         done_ack,
  input logic [NUM_EP-1:0]            ep_irq,
  input logic [NUM_EP-1:0][REG_W-1:0] ep_reg
);

  AST_STALL_ONLY_ACK_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_hs == 2'd3) |->
      (ep_reg[tok_ep][BIT_STALL] &&
       (ep_reg[tok_ep][3:0] == MODE_ACK_IN || ep_reg[tok_ep][3:0] == MODE_ACK_OUT))); // R4

  AST_NO_HS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |-> tok_hs == 2'd0); // R3

  generate
    for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
      AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_reg[i][BIT_RSV]); // R1

      AST_ACK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ack && done_ep == EP_W'(i)) |=> ep_reg[i][BIT_ACKED]); // R5

      AST_FW_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr_en && fw_addr == BASE_ADDR + ADDR_W'(i) && !(done_valid && done_ack))
          |=> !ep_reg[i][BIT_ACKED]); // R6

      AST_IRQ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ack && done_ep == EP_W'(i)) |=> ep_irq[i]); // R7

      AST_NO_IRQ_MASKED_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ack && done_ep == EP_W'(i) && !ep_reg[i][BIT_NAKIE])
          |=> !ep_irq[i]); // R7

      AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && done_ep == EP_W'(i)) |=> !ep_irq[i]); // R7

      AST_SIE_BLOCKS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_ack && done_ep != EP_W'(i) &&
         fw_wr_en && fw_addr == BASE_ADDR + ADDR_W'(i)) |=> $stable(ep_reg[i])); // R10
    end
  endgenerate

endmodule

bind usb_ep_mode_ctrl usb_ep_mode_ctrl_chk #(
  .NUM_EP    (NUM_EP),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .EP_W      (EP_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .fw_wr_en   (fw_wr_en),
  .fw_addr    (fw_addr),
  .tok_valid  (tok_valid),
  .tok_ep     (tok_ep),
  .tok_hs     (tok_hs),
  .done_valid (done_valid),
  .done_ep    (done_ep),
  .done_ack   (done_ack),
  .ep_irq     (ep_irq),
  .ep_reg     (ep_reg)
);

// File: tb/test_usb_ep_mode_ctrl.sv
`timescale 1ns/1ps
module test_usb_ep_mode_ctrl;

  logic       clk;
  logic       rst_n;
  logic       fw_wr_en;
  logic [7:0] fw_addr;
  logic [7:0] fw_wdata;
  logic [7:0] fw_rdata;
  logic       tok_valid;
  logic [0:0] tok_ep;
  logic       tok_in;
  logic [1:0] tok_hs;
  logic       done_valid;
  logic [0:0] done_ep;
  logic       done_in;
  logic       done_ack;
  logic [1:0] ep_irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  usb_ep_mode_ctrl i_usb_ep_mode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fw_wr_en(fw_wr_en), .fw_addr(fw_addr), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_in(tok_in), .tok_hs(tok_hs),
    .done_valid(done_valid), .done_ep(done_ep), .done_in(done_in), .done_ack(done_ack),
    .ep_irq(ep_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected handshake from R3/R4
  function automatic int exp_hs(input int mode, input bit stall, input bit is_in);
    case (mode)
      1: return is_in ? 2 : 0;
      2: return is_in ? (stall ? 3 : 1) : 0;
      3: return is_in ? 0 : 2;
      4: return is_in ? 0 : (stall ? 3 : 1);
      5: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic fw_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    fw_wr_en = 1'b1; fw_addr = a; fw_wdata = d;
    @(negedge clk);
    fw_wr_en = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    fw_addr = a;
    #1;
    chk(req, fw_rdata, exp);
  endtask

  // completion report, optional same-cycle firmware write, irq check after
  task automatic done_evt(input logic ep, input logic is_in, input logic ack,
                          input bit with_fw, input logic [7:0] a, input logic [7:0] d,
                          input string req, input int exp_irq);
    @(negedge clk);
    done_valid = 1'b1; done_ep = ep; done_in = is_in; done_ack = ack;
    if (with_fw) begin fw_wr_en = 1'b1; fw_addr = a; fw_wdata = d; end
    @(negedge clk);
    done_valid = 1'b0; fw_wr_en = 1'b0;
    chk(req, ep_irq, exp_irq);
    @(negedge clk);
    chk({req, " pulse end"}, ep_irq, 0);
  endtask

  task automatic t_reset();
    read_chk("R1 reset ep1", 8'h45, 8'h00);
    read_chk("R1 reset ep2", 8'h46, 8'h00);
    chk("R1 reset irq", ep_irq, 0);
    read_chk("R2 unmapped addr", 8'h47, 8'h00);
  endtask

  task automatic t_rw();
    fw_write(8'h45, 8'hFF);
    read_chk("R1 reserved and flag masked", 8'h45, 8'hAF);
    fw_write(8'h46, 8'h23);
    read_chk("R2 ep2 write", 8'h46, 8'h23);
    read_chk("R2 ep1 untouched", 8'h45, 8'hAF);
    read_chk("R2 below base", 8'h44, 8'h00);
  endtask

  task automatic t_handshake();
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 2; s++) begin
        fw_write(8'h46, {s[0], 3'b000, m[3:0]});
        for (int d = 0; d < 2; d++) begin
          @(negedge clk);
          tok_valid = 1'b1; tok_ep = 1'b1; tok_in = d[0];
          #1;
          chk((m == 2 || m == 4) ? "R4 stall handshake" : "R3 mode handshake",
              tok_hs, exp_hs(m, s[0], d[0]));
        end
        tok_valid = 1'b0;
        #1;
        chk("R3 no token", tok_hs, 0);
      end
    end
  endtask

  task automatic t_ack_paths();
    fw_write(8'h45, 8'h02);
    done_evt(1'b0, 1'b1, 1'b1, 0, 8'h00, 8'h00, "R7 irq on ack", 2'b01);
    read_chk("R5 R8 ack-in to nak-in", 8'h45, 8'h11);
    fw_write(8'h45, 8'h12);
    read_chk("R6 write clears flag", 8'h45, 8'h02);
    fw_write(8'h46, 8'h04);
    done_evt(1'b1, 1'b0, 1'b1, 0, 8'h00, 8'h00, "R7 irq ep2", 2'b10);
    read_chk("R8 ack-out to nak-out", 8'h46, 8'h13);
    fw_write(8'h46, 8'h03);
    done_evt(1'b1, 1'b1, 1'b1, 0, 8'h00, 8'h00, "R7 irq other mode", 2'b10);
    read_chk("R8 mode kept", 8'h46, 8'h13);
  endtask

  task automatic t_nak_irq();
    fw_write(8'h45, 8'h01);
    done_evt(1'b0, 1'b1, 1'b0, 0, 8'h00, 8'h00, "R7 masked nak", 2'b00);
    read_chk("R5 nak leaves flag", 8'h45, 8'h01);
    fw_write(8'h45, 8'h21);
    done_evt(1'b0, 1'b1, 1'b0, 0, 8'h00, 8'h00, "R7 enabled nak", 2'b01);
    read_chk("R5 nak no flag", 8'h45, 8'h21);
  endtask

  task automatic t_collisions();
    fw_write(8'h45, 8'h02);
    done_evt(1'b0, 1'b1, 1'b1, 1, 8'h45, 8'h05, "R9 irq", 2'b01);
    read_chk("R9 sie wins same reg", 8'h45, 8'h11);
    fw_write(8'h45, 8'h02);
    fw_write(8'h46, 8'h03);
    done_evt(1'b0, 1'b1, 1'b1, 1, 8'h46, 8'h04, "R10 irq", 2'b01);
    read_chk("R10 other reg write dropped", 8'h46, 8'h03);
    read_chk("R10 sie reg updated", 8'h45, 8'h11);
    done_evt(1'b0, 1'b1, 1'b0, 1, 8'h46, 8'h25, "R10 nak irq", 2'b00);
    read_chk("R10 nak does not block", 8'h46, 8'h25);
  endtask

  initial begin
    rst_n = 1'b0; fw_wr_en = 1'b0; fw_addr = 8'h00; fw_wdata = 8'h00;
    tok_valid = 1'b0; tok_ep = 1'b0; tok_in = 1'b0;
    done_valid = 1'b0; done_ep = 1'b0; done_in = 1'b0; done_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_handshake();
    t_ack_paths();
    t_nak_irq();
    t_collisions();
    done_flag = 1;
  end

  initial begin
    fork
      begin wait (done_flag); end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule